// File: doc/BRIEF.md
# Link Recovery Reset Watchdog

This block brings a stalled serial link back without disturbing its settings. It watches a link-up flag and a loopback-active flag. If the link stays down, with no loopback running, for a whole programmable interval, it starts a limited logic reset. That reset clears the datapath state and leaves every configuration field as it was. The interval is measured as a count of prescaler ticks, so one parameter set gives a multi-second interval in silicon and a bench can use a few dozen cycles.

The reset lives in a small command register as a self-clearing bit. The bit can be set in two ways. A host write can set it directly. An internal requester can also set it, and that requester then polls the bit at a fixed gap and gives up after a bounded number of reads, raising a timeout flag. The requester serves two sources. One is the watchdog. The other is a reconfiguration request, which only counts when the power mode or the loopback selection differs from the previous request. A reconfiguration that changes the power mode also writes the two lane power-down fields of the command register. Requests that arrive while a reset is already running are absorbed into that reset.

Top module: `link_recovery_wd`

## Requirements
- R1: After reset, `cmd_o` is all zeros and `logic_rst_o`, `wd_fire_o`, `req_busy_o` and `req_timeout_o` are low.
- R2: A host write with bit 14 set stores the whole word. Bit 14 (`logic_rst_o`) then stays high for exactly HOLD_CYC cycles and clears itself, and all other bits keep their written values.
- R3: During a reset in progress, a host write with bit 14 at 0 does not end the reset, and the write's other bits are stored at once.
- R4: With `link_up_i` and `loopback_i` both low, `wd_fire_o` pulses for one cycle in the TICK_DIV*WD_TICKS-th cycle after they went low, and that pulse starts a logic reset.
- R5: After firing, the watchdog rearms itself, so a link that stays down fires again exactly TICK_DIV*WD_TICKS cycles later.
- R6: While `link_up_i` or `loopback_i` is high, the watchdog never fires, and its count restarts from zero once both are low again.
- R7: A pulse on `reconf_req_i` starts a reset only when `lowpwr_i` or `loop_sel_i` differs from the values seen at the previous pulse (both taken as zero after reset). An unchanged request starts nothing.
- R8: A reconfiguration pulse whose `lowpwr_i` differs from the previous one sets bits 6 and 5 of the command register (lanes 2–3 and lanes 0–1 power-down) to `lowpwr_i`.
- R9: After setting bit 14, the requester reads the bit once every POLL_GAP cycles. `req_busy_o` drops at the first read that finds the bit clear, so it is high for POLL_GAP*(floor(HOLD_CYC/POLL_GAP)+1) cycles.
- R10: If all MAX_TRIES reads find bit 14 still set, `req_busy_o` drops after MAX_TRIES*POLL_GAP cycles and `req_timeout_o` goes high. It stays high until the next request starts, and that start clears it.
- R11: A watchdog or reconfiguration request that arrives while the requester is busy is dropped, and the reset in progress is not lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Link reports up |
| loopback_i | input | 1 | Some loopback mode is active |
| reconf_req_i | input | 1 | One-cycle reconfiguration request |
| lowpwr_i | input | 1 | Requested power mode, 1 = low power |
| loop_sel_i | input | LOOP_W | Requested loopback selection |
| host_wr_i | input | 1 | Host write strobe for the command register |
| host_wdata_i | input | CMD_W | Host write data |
| cmd_o | output | CMD_W | Command register contents |
| logic_rst_o | output | 1 | Logic reset in progress (bit 14) |
| wd_fire_o | output | 1 | Watchdog expiry pulse |
| req_busy_o | output | 1 | Requester is polling the reset bit |
| req_timeout_o | output | 1 | Last request ran out of polling tries |

## Verification
A wrong tick or timer count shows on `wd_fire_o` as a pulse that comes early or late against the TICK_DIV*WD_TICKS cycle mark. The error appears on the first expiry after the link drops, and a rearm fault shows on the second expiry. A faulty hold counter or a faulty self-clear path changes how long `logic_rst_o` is high. That difference is visible by the end of the first reset. A faulty change filter or power-field update shows up one cycle after the reconfiguration pulse, as a spurious or missing reset or wrong bits 6:5. Polling errors change the length of `req_busy_o` or the value of `req_timeout_o`, and both are read once the first request has finished.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

   typedef enum logic {
      REQ_IDLE = 1'b0,
      REQ_POLL = 1'b1
   } req_state_e;

   // counter width for values 0..n-1, never below one bit
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lrw_tick_gen.sv
module lrw_tick_gen #(
   parameter int unsigned DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   output logic tick_o
);
   import lrw_pkg::*;

   localparam int unsigned CW      = cnt_w(DIV);
   localparam bit          IS_POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt_q;

   generate
      if (IS_POW2) begin : g_wrap
         // counter wraps by itself at a power of two
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      cnt_q <= '0;
            else if (clear_i) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = &cnt_q;
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                         cnt_q <= '0;
            else if (clear_i || (cnt_q == LAST)) cnt_q <= '0;
            else                                 cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/lrw_timer.sv
module lrw_timer #(
   parameter int unsigned TICKS = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rearm_i,
   input  logic tick_i,
   output logic fire_o
);
   import lrw_pkg::*;

   localparam int unsigned   CW   = cnt_w(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;

   assign fire_o = !rearm_i && tick_i && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (rearm_i || fire_o) cnt_q <= '0;
      else if (tick_i)            cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/lrw_reconf_filter.sv
module lrw_reconf_filter #(
   parameter int unsigned LOOP_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              lowpwr_i,
   input  logic [LOOP_W-1:0] loop_sel_i,
   output logic              fire_o,
   output logic              pd_apply_o
);
   logic              pwr_q;
   logic [LOOP_W-1:0] loop_q;
   logic              pwr_diff;
   logic              loop_diff;

   assign pwr_diff   = (lowpwr_i != pwr_q);
   assign loop_diff  = (loop_sel_i != loop_q);
   assign fire_o     = req_i && (pwr_diff || loop_diff);
   assign pd_apply_o = req_i && pwr_diff;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pwr_q  <= 1'b0;
         loop_q <= '0;
      end else if (req_i) begin
         pwr_q  <= lowpwr_i;
         loop_q <= loop_sel_i;
      end
   end

endmodule

// File: rtl/lrw_cmd_reg.sv
module lrw_cmd_reg #(
   parameter int unsigned CMD_W     = 16,
   parameter int unsigned RST_BIT   = 14,
   parameter int unsigned PD_LO_BIT = 5,
   parameter int unsigned PD_HI_BIT = 6,
   parameter int unsigned HOLD_CYC  = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             host_wr_i,
   input  logic [CMD_W-1:0] host_wdata_i,
   input  logic             set_rst_i,
   input  logic             pd_apply_i,
   input  logic             pd_val_i,
   output logic [CMD_W-1:0] cmd_o
);
   import lrw_pkg::*;

   localparam int unsigned   HW        = cnt_w(HOLD_CYC);
   localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

   logic [CMD_W-1:0] cmd_q, cmd_d;
   logic [HW-1:0]    hold_q, hold_d;

   always_comb begin
      cmd_d  = cmd_q;
      hold_d = '0;
      if (host_wr_i) begin
         cmd_d          = host_wdata_i;
         // a written zero cannot cut a reset short
         cmd_d[RST_BIT] = host_wdata_i[RST_BIT] | cmd_q[RST_BIT];
      end
      if (pd_apply_i) begin
         cmd_d[PD_LO_BIT] = pd_val_i;
         cmd_d[PD_HI_BIT] = pd_val_i;
      end
      if (set_rst_i) cmd_d[RST_BIT] = 1'b1;
      if (cmd_q[RST_BIT]) begin
         if (hold_q == HOLD_LAST) begin
            cmd_d[RST_BIT] = 1'b0;
         end else begin
            hold_d = hold_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmd_q  <= '0;
         hold_q <= '0;
      end else begin
         cmd_q  <= cmd_d;
         hold_q <= hold_d;
      end
   end

   assign cmd_o = cmd_q;

endmodule

// File: rtl/lrw_requester.sv
module lrw_requester #(
   parameter int unsigned POLL_GAP  = 4,
   parameter int unsigned MAX_TRIES = 50
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic bit_i,
   output logic set_o,
   output logic busy_o,
   output logic timeout_o
);
   import lrw_pkg::*;

   localparam int unsigned   GW       = cnt_w(POLL_GAP);
   localparam int unsigned   TW       = cnt_w(MAX_TRIES);
   localparam logic [GW-1:0] GAP_LAST = GW'(POLL_GAP - 1);
   localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

   req_state_e    state_q;
   logic [GW-1:0] gap_q;
   logic [TW-1:0] tries_q;
   logic          timeout_q;

   assign set_o     = (state_q == REQ_IDLE) && start_i;
   assign busy_o    = (state_q == REQ_POLL);
   assign timeout_o = timeout_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= REQ_IDLE;
         gap_q     <= '0;
         tries_q   <= '0;
         timeout_q <= 1'b0;
      end else begin
         case (state_q)
            REQ_IDLE: begin
               if (start_i) begin
                  state_q   <= REQ_POLL;
                  gap_q     <= '0;
                  tries_q   <= '0;
                  timeout_q <= 1'b0;
               end
            end
            default: begin
               if (gap_q == GAP_LAST) begin
                  gap_q <= '0;
                  if (!bit_i) begin
                     state_q <= REQ_IDLE;
                  end else if (tries_q == TRY_LAST) begin
                     state_q   <= REQ_IDLE;
                     timeout_q <= 1'b1;
                  end else begin
                     tries_q <= tries_q + 1'b1;
                  end
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/link_recovery_wd.sv
module link_recovery_wd #(
   parameter int unsigned CMD_W     = 16,
   parameter int unsigned RST_BIT   = 14,
   parameter int unsigned PD_LO_BIT = 5,
   parameter int unsigned PD_HI_BIT = 6,
   parameter int unsigned LOOP_W    = 2,
   parameter int unsigned TICK_DIV  = 156250,
   parameter int unsigned WD_TICKS  = 5000,
   parameter int unsigned HOLD_CYC  = 32,
   parameter int unsigned POLL_GAP  = 156,
   parameter int unsigned MAX_TRIES = 50
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              link_up_i,
   input  logic              loopback_i,
   input  logic              reconf_req_i,
   input  logic              lowpwr_i,
   input  logic [LOOP_W-1:0] loop_sel_i,
   input  logic              host_wr_i,
   input  logic [CMD_W-1:0]  host_wdata_i,
   output logic [CMD_W-1:0]  cmd_o,
   output logic              logic_rst_o,
   output logic              wd_fire_o,
   output logic              req_busy_o,
   output logic              req_timeout_o
);

   generate
      if (RST_BIT >= CMD_W || PD_LO_BIT >= CMD_W || PD_HI_BIT >= CMD_W) begin : g_bad_pos
         $error("command field position outside register width");
      end
      if (RST_BIT == PD_LO_BIT || RST_BIT == PD_HI_BIT || PD_LO_BIT == PD_HI_BIT) begin : g_bad_overlap
         $error("command fields overlap");
      end
      if (TICK_DIV < 2 || WD_TICKS < 1 || HOLD_CYC < 1 || POLL_GAP < 1 || MAX_TRIES < 1) begin : g_bad_count
         $error("count parameter out of range");
      end
      if (LOOP_W < 1) begin : g_bad_loop
         $error("loop selection needs at least one bit");
      end
   endgenerate

   logic rearm;
   logic tick;
   logic reconf_fire;
   logic pd_apply;
   logic start;
   logic set_rst;
   logic [CMD_W-1:0] cmd;

   assign rearm = link_up_i | loopback_i;

   lrw_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (rearm),
      .tick_o  (tick)
   );

   lrw_timer #(.TICKS(WD_TICKS)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rearm_i (rearm),
      .tick_i  (tick),
      .fire_o  (wd_fire_o)
   );

   lrw_reconf_filter #(.LOOP_W(LOOP_W)) u_filter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (reconf_req_i),
      .lowpwr_i   (lowpwr_i),
      .loop_sel_i (loop_sel_i),
      .fire_o     (reconf_fire),
      .pd_apply_o (pd_apply)
   );

   // both reset sources share one requester; busy drops duplicates
   assign start = wd_fire_o | reconf_fire;

   lrw_requester #(.POLL_GAP(POLL_GAP), .MAX_TRIES(MAX_TRIES)) u_req (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .bit_i     (cmd[RST_BIT]),
      .set_o     (set_rst),
      .busy_o    (req_busy_o),
      .timeout_o (req_timeout_o)
   );

   lrw_cmd_reg #(
      .CMD_W     (CMD_W),
      .RST_BIT   (RST_BIT),
      .PD_LO_BIT (PD_LO_BIT),
      .PD_HI_BIT (PD_HI_BIT),
      .HOLD_CYC  (HOLD_CYC)
   ) u_cmd (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .host_wr_i    (host_wr_i),
      .host_wdata_i (host_wdata_i),
      .set_rst_i    (set_rst),
      .pd_apply_i   (pd_apply),
      .pd_val_i     (lowpwr_i),
      .cmd_o        (cmd)
   );

   assign cmd_o       = cmd;
   assign logic_rst_o = cmd[RST_BIT];

endmodule

// File: rtl/lrw_checker.sv
module lrw_checker #(
   parameter int unsigned CMD_W    = 16,
   parameter int unsigned RST_BIT  = 14,
   parameter int unsigned HOLD_CYC = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             link_up_i,
   input logic             loopback_i,
   input logic             reconf_req_i,
   input logic             host_wr_i,
   input logic [CMD_W-1:0] cmd_o,
   input logic             logic_rst_o,
   input logic             wd_fire_o,
   input logic             req_busy_o,
   input logic             req_timeout_o
);
   import lrw_pkg::*;

   localparam int unsigned      RW   = cnt_w(HOLD_CYC + 2);
   localparam logic [CMD_W-1:0] KEEP = ~(CMD_W'(1) << RST_BIT);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          run_q <= '0;
      else if (!logic_rst_o)                run_q <= '0;
      else if (run_q != {RW{1'b1}})         run_q <= run_q + 1'b1;
   end

   assert_hold_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RW'(HOLD_CYC));

   assert_config_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(logic_rst_o) && !$past(host_wr_i) && !$past(reconf_req_i))
      |-> ((cmd_o & KEEP) == ($past(cmd_o) & KEEP)));

   assert_no_fire_when_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_fire_o |-> (!link_up_i && !loopback_i));

   assert_done_on_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(req_busy_o) && !req_timeout_o) |-> !$past(logic_rst_o));

   assert_timeout_bit_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_timeout_o) |-> $past(logic_rst_o));

   assert_busy_with_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_busy_o) |-> logic_rst_o);

endmodule

bind link_recovery_wd lrw_checker #(
   .CMD_W    (CMD_W),
   .RST_BIT  (RST_BIT),
   .HOLD_CYC (HOLD_CYC)
) u_lrw_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .link_up_i     (link_up_i),
   .loopback_i    (loopback_i),
   .reconf_req_i  (reconf_req_i),
   .host_wr_i     (host_wr_i),
   .cmd_o         (cmd_o),
   .logic_rst_o   (logic_rst_o),
   .wd_fire_o     (wd_fire_o),
   .req_busy_o    (req_busy_o),
   .req_timeout_o (req_timeout_o)
);

// File: tb/link_recovery_wd_tb_top.sv
module link_recovery_wd_tb_top;

   localparam int CLK_PERIOD = 10;

   localparam int P_DIV   = 4;
   localparam int P_TICKS = 5;
   localparam int P_HOLD  = 8;
   localparam int P_GAP   = 4;
   localparam int P_MAX   = 50;
   localparam int WD_N    = P_DIV * P_TICKS;
   localparam int BUSY_OK = P_GAP * (P_HOLD / P_GAP + 1);

   localparam int T_HOLD  = 40;
   localparam int T_GAP   = 2;
   localparam int T_MAX   = 4;
   localparam int BUSY_TO = T_GAP * T_MAX;

   // {lowpwr, loop_sel[1:0], reset expected, power-down bits expected}
   localparam logic [4:0] VEC [0:6] = '{
      5'b0_00_0_0, 5'b1_00_1_1, 5'b1_00_0_1, 5'b1_10_1_1,
      5'b0_10_1_0, 5'b0_10_0_0, 5'b0_00_1_0
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up = 1'b1;
   logic        loopback = 1'b0;
   logic        reconf = 1'b0;
   logic        lowpwr = 1'b0;
   logic [1:0]  loop_sel = 2'b00;
   logic        host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] cmd;
   logic        lrst, fire, busy, tmo;

   logic        to_reconf = 1'b0;
   logic        to_lowpwr = 1'b0;
   logic [15:0] to_cmd;
   logic        to_lrst, to_fire, to_busy, to_tmo;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   link_recovery_wd #(
      .TICK_DIV(P_DIV), .WD_TICKS(P_TICKS), .HOLD_CYC(P_HOLD),
      .POLL_GAP(P_GAP), .MAX_TRIES(P_MAX)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .link_up_i(link_up), .loopback_i(loopback),
      .reconf_req_i(reconf), .lowpwr_i(lowpwr), .loop_sel_i(loop_sel),
      .host_wr_i(host_wr), .host_wdata_i(host_wdata), .cmd_o(cmd),
      .logic_rst_o(lrst), .wd_fire_o(fire), .req_busy_o(busy), .req_timeout_o(tmo)
   );

   link_recovery_wd #(
      .TICK_DIV(3), .WD_TICKS(7), .HOLD_CYC(T_HOLD),
      .POLL_GAP(T_GAP), .MAX_TRIES(T_MAX)
   ) dut_to_i (
      .clk_i(clk), .rst_ni(rst_n), .link_up_i(1'b1), .loopback_i(1'b0),
      .reconf_req_i(to_reconf), .lowpwr_i(to_lowpwr), .loop_sel_i(2'b00),
      .host_wr_i(1'b0), .host_wdata_i(16'h0000), .cmd_o(to_cmd),
      .logic_rst_o(to_lrst), .wd_fire_o(to_fire), .req_busy_o(to_busy),
      .req_timeout_o(to_tmo)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic count_main(output int cr, output int cb);
      cr = 0; cb = 0;
      for (int i = 0; i < 400; i++) begin
         if (!lrst && !busy) break;
         cr += int'(lrst); cb += int'(busy);
         @(negedge clk);
      end
   endtask

   task automatic count_to(output int cr, output int cb);
      cr = 0; cb = 0;
      for (int i = 0; i < 400; i++) begin
         if (!to_lrst && !to_busy) break;
         cr += int'(to_lrst); cb += int'(to_busy);
         @(negedge clk);
      end
   endtask

   task automatic wait_fire(output int k);
      k = 0;
      while (!fire && k < 200) begin
         @(negedge clk);
         k++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int cr, cb, k, nf;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 cmd", cmd, 16'h0000);
      check("R1 flags", {lrst, fire, busy, tmo}, 4'b0000);

      // R2 / R3 host write of the reset bit
      host_wr = 1'b1; host_wdata = 16'h4003;
      @(negedge clk);
      host_wr = 1'b0;
      check("R2 write stored", cmd, 16'h4003);
      cr = 1;
      @(negedge clk);
      cr++;
      host_wr = 1'b1; host_wdata = 16'h0080;
      @(negedge clk);
      host_wr = 1'b0;
      check("R3 zero write keeps reset", cmd, 16'h4080);
      count_main(k, cb);
      check("R2 hold length", cr + k, P_HOLD);
      check("R2 requester idle on host reset", cb, 0);
      check("R2 config kept after clear", cmd, 16'h0080);

      // R7 / R8 / R9 table of reconfiguration requests
      for (int v = 0; v < 7; v++) begin
         lowpwr = VEC[v][4]; loop_sel = VEC[v][3:2]; reconf = 1'b1;
         @(negedge clk);
         reconf = 1'b0;
         check("R7 reset started", lrst, VEC[v][1]);
         check("R8 power-down bits", cmd[6:5], {2{VEC[v][0]}});
         if (VEC[v][1]) begin
            count_main(cr, cb);
            check("R2 hold length via request", cr, P_HOLD);
            check("R9 busy length", cb, BUSY_OK);
         end else begin
            check("R7 no request", busy, 1'b0);
         end
         repeat (3) @(negedge clk);
      end

      // R11 second request while busy is absorbed
      lowpwr = 1'b1; reconf = 1'b1;
      @(negedge clk);
      reconf = 1'b0;
      cr = 0; cb = 0;
      for (int i = 0; i < 400; i++) begin
         if (!lrst && !busy && i > 3) break;
         cr += int'(lrst); cb += int'(busy);
         if (i == 2) begin lowpwr = 1'b0; reconf = 1'b1; end
         else reconf = 1'b0;
         @(negedge clk);
      end
      check("R11 merged hold length", cr, P_HOLD);
      check("R11 merged busy length", cb, BUSY_OK);
      check("R8 leaving low power", cmd[6:5], 2'b00);

      // R4 / R5 watchdog expiry and rearm
      link_up = 1'b0;
      wait_fire(k);
      check("R4 first expiry cycle", k, WD_N - 1);
      @(negedge clk);
      check("R4 expiry starts reset", lrst, 1'b1);
      k = 1;
      while (!fire && k < 200) begin
         @(negedge clk);
         k++;
      end
      check("R5 rearmed interval", k, WD_N);
      link_up = 1'b1;
      repeat (BUSY_OK + 4) @(negedge clk);

      // R6 loopback and link-up hold the timer
      loopback = 1'b1; link_up = 1'b0;
      nf = 0;
      for (int i = 0; i < 3 * WD_N; i++) begin
         nf += int'(fire);
         @(negedge clk);
      end
      check("R6 no expiry during loopback", nf, 0);
      loopback = 1'b0;
      repeat (10) @(negedge clk);
      link_up = 1'b1;
      @(negedge clk);
      link_up = 1'b0;
      wait_fire(k);
      check("R6 count restarts after link blip", k, WD_N - 1);
      link_up = 1'b1;
      repeat (BUSY_OK + 4) @(negedge clk);

      // R10 polling gives up on a long reset
      to_lowpwr = 1'b1; to_reconf = 1'b1;
      @(negedge clk);
      to_reconf = 1'b0;
      check("R10 timeout low at start", to_tmo, 1'b0);
      count_to(cr, cb);
      check("R10 busy length on timeout", cb, BUSY_TO);
      check("R10 reset still full length", cr, T_HOLD);
      check("R10 timeout raised", to_tmo, 1'b1);
      to_lowpwr = 1'b0; to_reconf = 1'b1;
      @(negedge clk);
      to_reconf = 1'b0;
      check("R10 timeout cleared by new request", {to_tmo, to_busy}, 2'b01);
      count_to(cr, cb);
      check("R10 timeout raised again", to_tmo, 1'b1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule